// File: doc/BRIEF.md
# Dual-Mode Cell/Packet Receive Drain Port

This block sits at the far end of a receive path. It drains a show-ahead receive FIFO onto a 16-bit parallel bus toward a link-layer device. The link-layer side controls the transfer with an active-low enable. While the enable is low and the FIFO holds data, one entry is popped per clock. That entry appears on the bus at the following rising edge, together with a data-valid strobe and boundary markers.

The port runs in one of two modes. In cell mode it carries fixed-size cells and flags the first word of each cell. A cell is 27 words when the bus carries 16-bit words (the last byte is padded) and 53 words when it carries one byte per transfer. In packet mode it carries variable-length packets and flags each packet's first word. The FIFO supplies end-of-packet and odd-byte tags, and the port passes them on with the last word.

An optional chunk sub-mode changes the meaning of the start marker. It then pulses at the first word of every fixed-size chunk. A separate start-of-frame output takes over the job of marking packet starts. Upstream logic that does not use the port ties the enable low.

Top module: `rxq_drain_port`

## Requirements
- R1: `fifo_pop` is high in exactly those cycles where `oe_n` is low and `fifo_empty` is low, combinationally in the same cycle.
- R2: A word popped in one cycle is on `bus_data` with `bus_valid` high after the next rising edge. In 16-bit mode (`cfg_wide`=1) it appears unchanged; in byte mode (`cfg_wide`=0) bits 15:8 read zero and bits 7:0 carry the FIFO's low byte.
- R3: `bus_drive` (1 = drivers on, 0 = tri-state) equals the inverse of `oe_n` sampled at the previous rising edge. While `bus_drive` is 0, `bus_valid` is 0.
- R4: A cycle without a pop, whether from an empty FIFO or a negated enable, leaves `bus_valid` low after the next edge. It also leaves `bus_data` unchanged and all boundary markers low.
- R5: In cell mode (`cfg_pkt`=0) with `cfg_wide`=1, `bus_start` is high on the word with pop index k exactly when k mod 27 = 0. The index k counts pops from reset, starting at 0.
- R6: In cell mode with `cfg_wide`=0, `bus_start` is high exactly when k mod 53 = 0.
- R7: In packet mode (`cfg_pkt`=1, `cfg_chunk`=0), `bus_start` is high on the first word after reset and on the first word after each word tagged with `fifo_eop`.
- R8: `bus_eop` is high on a delivered word whose FIFO entry carried `fifo_eop`. `bus_odd` is high only when the word also carried `fifo_odd` and is an end-of-packet word. Both stay low in cell mode.
- R9: In chunk sub-mode (`cfg_pkt`=1, `cfg_chunk`=1), `bus_start` is high on the word with index i within its packet exactly when i mod CHUNK_WORDS = 0 (32 by default). The index i restarts at 0 with each packet.
- R10: In chunk sub-mode, `bus_sof` is high on the first word of each packet. Outside chunk sub-mode, `bus_sof` is always low.
- R11: During and right after reset, all outputs are low: `bus_data` is zero, `bus_drive` and `bus_valid` are 0, and all markers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pkt | input | 1 | 1 = packet mode, 0 = cell mode |
| cfg_chunk | input | 1 | 1 = chunk sub-mode (packet mode only) |
| cfg_wide | input | 1 | 1 = 16-bit words, 0 = one byte per transfer |
| oe_n | input | 1 | Active-low output enable from the link layer |
| fifo_empty | input | 1 | FIFO has no entry at its head |
| fifo_word | input | 16 | Show-ahead FIFO head data |
| fifo_eop | input | 1 | Head entry ends a packet |
| fifo_odd | input | 1 | Head entry's last word holds one valid byte |
| fifo_pop | output | 1 | Pop strobe to the FIFO |
| bus_data | output | 16 | Registered output data |
| bus_drive | output | 1 | Driver enable for the tri-state bus |
| bus_valid | output | 1 | `bus_data` holds a newly popped word |
| bus_start | output | 1 | Start of cell / packet / chunk |
| bus_sof | output | 1 | Start of packet in chunk sub-mode |
| bus_eop | output | 1 | Last word of a packet |
| bus_odd | output | 1 | Last word carries a single valid byte |

## Verification
`fifo_pop` is combinational, so the bench checks it one time step after driving inputs on the falling edge. Everything on the bus side sits exactly one register behind the stimulus: data, valid, drive and markers are sampled on the falling edge that follows the next rising edge. The expected position of each boundary marker comes from the bench's own running pop count, or from its index within the packet, using modulo arithmetic. The bench inserts empty-FIFO and negated-enable cycles between pops, so R4 is checked at the same one-edge offset as the pops.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int RXQ_DW = 16;

    typedef struct packed {
        logic [RXQ_DW-1:0] data;
        logic              drive;
        logic              valid;
        logic              start;
        logic              sof;
        logic              eop;
        logic              odd;
    } rxq_out_t;
endpackage

// File: rtl/rxq_cell_pos.sv
module rxq_cell_pos #(
    parameter int CELL_BYTES = 53
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic wide,
    output logic first
);
    localparam int PW = $clog2(CELL_BYTES);
    localparam logic [PW-1:0] WIDE_LAST   = PW'((CELL_BYTES + 1) / 2 - 1);
    localparam logic [PW-1:0] NARROW_LAST = PW'(CELL_BYTES - 1);

    logic [PW-1:0] pos_d, pos_q;
    logic [PW-1:0] last_pos;

    always_comb begin
        last_pos = wide ? WIDE_LAST : NARROW_LAST;
        first    = (pos_q == '0);
        pos_d    = pos_q;
        if (adv) begin
            pos_d = (pos_q >= last_pos) ? '0 : pos_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    // R6
    pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= NARROW_LAST);

    // R5
    cell_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && pos_q == last_pos) |=> first);
endmodule

// File: rtl/rxq_pkt_pos.sv
module rxq_pkt_pos #(
    parameter int CHUNK_WORDS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic last,
    output logic pkt_first,
    output logic chunk_first
);
    localparam int CW = (CHUNK_WORDS > 1) ? $clog2(CHUNK_WORDS) : 1;
    localparam logic [CW-1:0] CHUNK_LAST = CW'(CHUNK_WORDS - 1);

    typedef struct packed {
        logic          mid;
        logic [CW-1:0] chk;
    } pkt_st_t;

    pkt_st_t st_d, st_q;
    logic [CW-1:0] base;

    always_comb begin
        pkt_first   = !st_q.mid;
        base        = pkt_first ? '0 : st_q.chk;
        chunk_first = (base == '0);
        st_d        = st_q;
        if (adv) begin
            st_d.mid = !last;
            st_d.chk = (base == CHUNK_LAST) ? '0 : base + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9
    chunk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.chk <= CHUNK_LAST);

    // R7
    pkt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && last) |=> pkt_first);
endmodule

// File: rtl/rxq_drain_port.sv
module rxq_drain_port
    import rxq_pkg::*;
#(
    parameter int CELL_BYTES  = 53,
    parameter int CHUNK_WORDS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_pkt,
    input  logic              cfg_chunk,
    input  logic              cfg_wide,
    input  logic              oe_n,
    input  logic              fifo_empty,
    input  logic [RXQ_DW-1:0] fifo_word,
    input  logic              fifo_eop,
    input  logic              fifo_odd,
    output logic              fifo_pop,
    output logic [RXQ_DW-1:0] bus_data,
    output logic              bus_drive,
    output logic              bus_valid,
    output logic              bus_start,
    output logic              bus_sof,
    output logic              bus_eop,
    output logic              bus_odd
);
    rxq_out_t out_d, out_q;
    logic     cell_first, pkt_first, chunk_first;
    logic     cell_adv, pkt_adv;

    assign cell_adv = fifo_pop && !cfg_pkt;
    assign pkt_adv  = fifo_pop &&  cfg_pkt;

    rxq_cell_pos #(.CELL_BYTES(CELL_BYTES)) u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (cell_adv),
        .wide  (cfg_wide),
        .first (cell_first)
    );

    rxq_pkt_pos #(.CHUNK_WORDS(CHUNK_WORDS)) u_pkt (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv         (pkt_adv),
        .last        (fifo_eop),
        .pkt_first   (pkt_first),
        .chunk_first (chunk_first)
    );

    always_comb begin
        fifo_pop    = !oe_n && !fifo_empty;
        out_d       = out_q;
        out_d.drive = !oe_n;
        out_d.valid = fifo_pop;
        out_d.start = 1'b0;
        out_d.sof   = 1'b0;
        out_d.eop   = 1'b0;
        out_d.odd   = 1'b0;
        if (fifo_pop) begin
            out_d.data = cfg_wide ? fifo_word
                                  : {{(RXQ_DW-8){1'b0}}, fifo_word[7:0]};
            if (!cfg_pkt) begin
                out_d.start = cell_first;
            end else begin
                if (cfg_chunk) begin
                    out_d.start = chunk_first;
                    out_d.sof   = pkt_first;
                end else begin
                    out_d.start = pkt_first;
                end
                out_d.eop = fifo_eop;
                out_d.odd = fifo_eop && fifo_odd;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign bus_data  = out_q.data;
    assign bus_drive = out_q.drive;
    assign bus_valid = out_q.valid;
    assign bus_start = out_q.start;
    assign bus_sof   = out_q.sof;
    assign bus_eop   = out_q.eop;
    assign bus_odd   = out_q.odd;

    // R2
    pop_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> bus_valid);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_pop |=> (!bus_valid && $stable(bus_data)));

    // R3
    tristate_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_drive |-> !bus_valid);

    // R8
    odd_needs_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_odd |-> bus_eop);

    // R10
    sof_is_chunk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sof |-> bus_start);
endmodule

// File: tb/rxq_drain_port_bench.sv
module rxq_drain_port_bench;
    localparam int CHUNK = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_pkt = 1'b0, cfg_chunk = 1'b0, cfg_wide = 1'b1;
    logic        oe_n = 1'b1, fifo_empty = 1'b1, fifo_eop = 1'b0, fifo_odd = 1'b0;
    logic [15:0] fifo_word = '0;
    logic        fifo_pop;
    logic [15:0] bus_data;
    logic        bus_drive, bus_valid, bus_start, bus_sof, bus_eop, bus_odd;

    int          tests = 0;
    int          fails = 0;
    logic [15:0] exp_data = '0;
    int          seq = 0;

    always #4 clk = ~clk;

    rxq_drain_port #(.CELL_BYTES(53), .CHUNK_WORDS(CHUNK)) u_rxq_drain_port (
        .clk(clk), .rst_n(rst_n), .cfg_pkt(cfg_pkt), .cfg_chunk(cfg_chunk),
        .cfg_wide(cfg_wide), .oe_n(oe_n), .fifo_empty(fifo_empty),
        .fifo_word(fifo_word), .fifo_eop(fifo_eop), .fifo_odd(fifo_odd),
        .fifo_pop(fifo_pop), .bus_data(bus_data), .bus_drive(bus_drive),
        .bus_valid(bus_valid), .bus_start(bus_start), .bus_sof(bus_sof),
        .bus_eop(bus_eop), .bus_odd(bus_odd)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic pkt, input logic chunk, input logic wide);
        @(negedge clk);
        rst_n = 1'b0; oe_n = 1'b1; fifo_empty = 1'b1;
        cfg_pkt = pkt; cfg_chunk = chunk; cfg_wide = wide;
        repeat (2) @(negedge clk);
        // R11 reset state
        chk("R11 data", bus_data, 0);
        chk("R11 flags", {bus_drive, bus_valid, bus_start, bus_sof, bus_eop, bus_odd}, 0);
        rst_n = 1'b1;
        exp_data = '0;
    endtask

    // Called at a falling edge; drives one cycle and checks its outcome.
    task automatic cyc(input logic oen, input logic emp, input logic e,
                       input logic o, input logic x_start, input logic x_sof,
                       input string tag);
        logic pop;
        logic [15:0] w;
        seq++;
        w = 16'hA55A ^ 16'(seq * 16'h0137);
        oe_n = oen; fifo_empty = emp; fifo_word = w; fifo_eop = e; fifo_odd = o;
        pop = !oen && !emp;
        #1;
        chk("R1 pop", fifo_pop, pop);
        if (pop) exp_data = cfg_wide ? w : {8'h00, w[7:0]};
        @(negedge clk);
        chk("R3 drive", bus_drive, !oen);
        chk(pop ? "R2 valid" : "R4 valid", bus_valid, pop);
        chk(pop ? "R2 data" : "R4 data", bus_data, exp_data);
        chk(tag, bus_start, pop && x_start);
        chk("R10 sof", bus_sof, pop && x_sof);
        chk("R8 eop", bus_eop, pop && cfg_pkt && e);
        chk("R8 odd", bus_odd, pop && cfg_pkt && e && o);
    endtask

    task automatic idles(input int n);
        if (n % 5 == 3) cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R4 start");
        if (n % 11 == 4) cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R4 start");
    endtask

    initial begin
        // R5: 16-bit cell mode, period 27
        do_reset(1'b0, 1'b0, 1'b1);
        for (int k = 0; k < 27 * 3 + 4; k++) begin
            idles(k);
            cyc(1'b0, 1'b0, k[0], 1'b1, (k % 27) == 0, 1'b0, "R5 start");
        end
        // R6: byte cell mode, period 53
        do_reset(1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 53 * 3 + 4; k++) begin
            idles(k);
            cyc(1'b0, 1'b0, k[1], 1'b1, (k % 53) == 0, 1'b0, "R6 start");
        end
        // R7, R8: packet mode, lengths 1..40
        do_reset(1'b1, 1'b0, 1'b1);
        for (int len = 1; len <= 40; len++) begin
            for (int i = 0; i < len; i++) begin
                idles(len + i);
                cyc(1'b0, 1'b0, i == len - 1, len[0], i == 0, 1'b0, "R7 start");
            end
        end
        // R9, R10: chunk sub-mode, lengths 1..70
        do_reset(1'b1, 1'b1, 1'b1);
        for (int len = 1; len <= 70; len++) begin
            for (int i = 0; i < len; i++) begin
                idles(len * 3 + i);
                cyc(1'b0, 1'b0, i == len - 1, len[1], (i % CHUNK) == 0, i == 0,
                    "R9 start");
            end
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule